// File: doc/BRIEF.md
# Reset Cause Latch Register

This block holds one byte of status that tells software which monitored source last forced a system reset. It watches five single-cycle fault strobes: three low-voltage monitors, a watchdog and a manual reset input. After power-up every flag reads 0, so nothing is being recorded yet. Software arms monitoring by writing ones into the flag bits. When a source fails, the matching flag drops from 1 to 0 and stays at 0 until software writes it again. The usual sequence is: read the byte, note which bits are 0, then write all ones to re-arm.

The register sits behind an upstream bus protocol layer. That layer passes down a 4-bit device-select code, an 8-bit address, read and write strobes, and a flag that marks the first data byte of a transaction. The block answers only when the select code and the address both match its parameters (defaults 4'b1011 and 8'hFF). No write-enable unlock is needed. A response comes one cycle after the strobe: a valid pulse, an acknowledge bit and the read data.

Top module: `reset_cause_latch`

## Requirements
- R1: After reset all flags are 0, a read returns 8'h00, and no response is pending.
- R2: Flags sit at bit 7 (low-voltage monitor 1), bit 6 (monitor 2), bit 5 (monitor 3), bit 4 (watchdog) and bit 3 (manual reset). Bits 2..0 always read 0, and the values written to them are ignored.
- R3: A write strobe with matching select and address, marked as the first data byte, loads bits 7..3 from the data byte. In the next cycle it gives a response with valid=1 and ack=1. No unlock step comes first.
- R4: A fault strobe clears its flag in the cycle after the strobe. The flag stays 0 through any number of reads until a write sets it again.
- R5: A fault strobe in the same cycle as an accepted write wins: its flag ends up 0 whatever the write carried.
- R6: A matching write that is not the first data byte gets a response with valid=1 and ack=0 (no-acknowledge) and leaves the flags unchanged.
- R7: An access with a non-matching select code or address gives no response and does not change the flags.
- R8: A matching read gives, one cycle later, valid=1, ack=1 and exactly one byte: the flags as they stood at the strobe. The read does not change the flags, and it is served at any time.
- R9: Several fault strobes in one cycle each clear their own flag and leave the other flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 4 | Device-select code of the current access |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_first | input | 1 | The write carries the first data byte of its transaction |
| bus_wdata | input | 8 | Write data byte |
| lv_fault | input | 3 | Low-voltage fault strobes; index 0 is monitor 1 |
| wd_fault | input | 1 | Watchdog fault strobe |
| mr_fault | input | 1 | Manual reset fault strobe |
| resp_valid | output | 1 | Response present (one cycle after a matching strobe) |
| resp_ack | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| resp_rdata | output | 8 | Read data byte; 0 when the response is not to a read |

## Verification
A wrong internal flag can only be seen through the next read, which reports it one cycle after that read's strobe. For this reason every write and every fault in the bench is followed at once by a read-back. A flag that rises without a write, or that fails to fall after a fault, then shows within two cycles as a wrong byte. A wrong decode shows up in the cycle after the strobe in one of two ways: a response that should not be there, or an ack value with the wrong polarity.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
  localparam int RCL_DATA_W = 8;
  localparam int RCL_NUM_LV = 3;
  localparam int RCL_FLAG_W = RCL_NUM_LV + 2;
  localparam int RCL_LOW_W  = RCL_DATA_W - RCL_FLAG_W;

  typedef struct packed {
    logic                  valid;
    logic                  ack;
    logic [RCL_DATA_W-1:0] data;
  } rcl_resp_t;

  // Next flag state: a write loads the upper byte field, then any fault clears.
  function automatic logic [RCL_FLAG_W-1:0] rcl_next(
    input logic [RCL_FLAG_W-1:0] cur,
    input logic [RCL_DATA_W-1:0] wbyte,
    input logic                  we,
    input logic [RCL_FLAG_W-1:0] fault
  );
    logic [RCL_FLAG_W-1:0] n;
    n = we ? wbyte[RCL_DATA_W-1 -: RCL_FLAG_W] : cur;
    return n & ~fault;
  endfunction

  // Place flags in the upper bits and zero-fill the low bits.
  function automatic logic [RCL_DATA_W-1:0] rcl_pack(input logic [RCL_FLAG_W-1:0] f);
    return {f, {RCL_LOW_W{1'b0}}};
  endfunction
endpackage

// File: rtl/rcl_decode.sv
module rcl_decode #(
  parameter int SEL_W    = 4,
  parameter int ADDR_W   = 8,
  parameter logic [SEL_W-1:0]  SEL_CODE = 4'b1011,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFF
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              first,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              wr_accept
);
  logic match;
  always_comb begin
    match     = (sel == SEL_CODE) && (addr == REG_ADDR);
    rd_hit    = match && rd && !wr;
    wr_hit    = match && wr;
    wr_accept = wr_hit && first;
  end
endmodule

// File: rtl/rcl_flags.sv
module rcl_flags
  import rcl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [RCL_DATA_W-1:0] wbyte,
  input  logic [RCL_FLAG_W-1:0] fault,
  output logic [RCL_FLAG_W-1:0] flags_q
);
  logic [RCL_FLAG_W-1:0] flags_d;
  always_comb flags_d = rcl_next(flags_q, wbyte, we, fault);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/rcl_resp.sv
module rcl_resp
  import rcl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_hit,
  input  logic                  wr_hit,
  input  logic                  wr_accept,
  input  logic [RCL_FLAG_W-1:0] flags_q,
  output rcl_resp_t             resp_q
);
  rcl_resp_t resp_d;
  always_comb begin
    resp_d.valid = rd_hit || wr_hit;
    resp_d.ack   = rd_hit || wr_accept;
    resp_d.data  = rd_hit ? rcl_pack(flags_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else        resp_q <= resp_d;
  end
endmodule

// File: rtl/reset_cause_latch.sv
module reset_cause_latch
  import rcl_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 8,
  parameter logic [SEL_W-1:0]  SEL_CODE = 4'b1011,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SEL_W-1:0]      bus_sel,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic                  bus_first,
  input  logic [RCL_DATA_W-1:0] bus_wdata,
  input  logic [RCL_NUM_LV-1:0] lv_fault,
  input  logic                  wd_fault,
  input  logic                  mr_fault,
  output logic                  resp_valid,
  output logic                  resp_ack,
  output logic [RCL_DATA_W-1:0] resp_rdata
);
  logic                  rd_hit, wr_hit, wr_accept;
  logic [RCL_FLAG_W-1:0] fault_vec;
  logic [RCL_FLAG_W-1:0] flags_q;
  rcl_resp_t             resp_q;

  // Monitor 1 goes to the top flag bit, then monitors 2, 3, watchdog, manual.
  for (genvar i = 0; i < RCL_NUM_LV; i++) begin : g_lv_map
    assign fault_vec[RCL_FLAG_W-1-i] = lv_fault[i];
  end
  assign fault_vec[1] = wd_fault;
  assign fault_vec[0] = mr_fault;

  rcl_decode #(
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .SEL_CODE(SEL_CODE), .REG_ADDR(REG_ADDR)
  ) u_dec (
    .sel(bus_sel), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .first(bus_first),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .wr_accept(wr_accept)
  );

  rcl_flags u_flags (
    .clk(clk), .rst_n(rst_n), .we(wr_accept), .wbyte(bus_wdata),
    .fault(fault_vec), .flags_q(flags_q)
  );

  rcl_resp u_resp (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .wr_hit(wr_hit),
    .wr_accept(wr_accept), .flags_q(flags_q), .resp_q(resp_q)
  );

  assign resp_valid = resp_q.valid;
  assign resp_ack   = resp_q.ack;
  assign resp_rdata = resp_q.data;
endmodule

// File: rtl/rcl_checker.sv
module rcl_checker
  import rcl_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_hit,
  input logic                  wr_hit,
  input logic                  wr_accept,
  input logic [RCL_FLAG_W-1:0] fault_vec,
  input logic [RCL_FLAG_W-1:0] flags_q,
  input logic                  resp_valid,
  input logic                  resp_ack,
  input logic [RCL_DATA_W-1:0] resp_rdata
);
  assert_fault_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_vec) |=> ((flags_q & $past(fault_vec)) == '0));

  assert_rise_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q)) != '0) |-> $past(wr_accept));

  assert_second_byte_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wr_accept) |=> (resp_valid && !resp_ack && $stable(flags_q)));

  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_rdata[RCL_LOW_W-1:0] == '0));

  assert_no_stray_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(rd_hit || wr_hit));

  assert_read_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (resp_valid && resp_ack &&
                resp_rdata[RCL_DATA_W-1 -: RCL_FLAG_W] == $past(flags_q)));
endmodule

bind reset_cause_latch rcl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .wr_hit(wr_hit),
  .wr_accept(wr_accept), .fault_vec(fault_vec), .flags_q(flags_q),
  .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_rdata(resp_rdata)
);

// File: tb/tb_reset_cause_latch.sv
module tb_reset_cause_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_sel = '0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_first = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [2:0] lv_fault = '0;
  logic       wd_fault = 1'b0, mr_fault = 1'b0;
  logic       resp_valid, resp_ack;
  logic [7:0] resp_rdata;

  int vectors = 0;
  int errors  = 0;
  logic [7:0] model = 8'h00;  // expected register byte, bits 2..0 kept 0

  always #4 clk = ~clk;  // 125 MHz

  reset_cause_latch dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_first(bus_first), .bus_wdata(bus_wdata),
    .lv_fault(lv_fault), .wd_fault(wd_fault), .mr_fault(mr_fault),
    .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_rdata(resp_rdata)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {valid,ack,data}=%03h expected %03h", req, act, exp);
    end
  endtask

  // Fault mask in byte position: monitor i -> bit 7-i, watchdog bit 4, manual bit 3.
  function automatic logic [7:0] fault_byte(input logic [2:0] lv, input logic wd, input logic mr);
    return {lv[0], lv[1], lv[2], wd, mr, 3'b000};
  endfunction

  // One access plus optional faults in the same cycle; response checked next cycle.
  task automatic access(input string req, input logic [3:0] sel, input logic [7:0] addr,
                        input logic wr, input logic rd, input logic first,
                        input logic [7:0] wdata, input logic [4:0] flt);
    logic hit;
    logic [9:0] exp;
    logic [7:0] fb;
    @(negedge clk);
    bus_sel = sel; bus_addr = addr; bus_wr = wr; bus_rd = rd;
    bus_first = first; bus_wdata = wdata;
    lv_fault = flt[4:2]; wd_fault = flt[1]; mr_fault = flt[0];
    hit = (sel == 4'b1011) && (addr == 8'hFF);
    fb  = fault_byte(flt[4:2], flt[1], flt[0]);
    if (hit && rd && !wr)      exp = {1'b1, 1'b1, model};
    else if (hit && wr)        exp = {1'b1, first, 8'h00};
    else                       exp = 10'h000;
    if (hit && wr && first) model = wdata & 8'hF8;
    model = model & ~fb;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; lv_fault = '0; wd_fault = 1'b0; mr_fault = 1'b0;
    check(req, {resp_valid, resp_ack, resp_rdata}, exp);
  endtask

  task automatic rd_back(input string req);
    access(req, 4'b1011, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00, 5'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {resp_valid, resp_ack, resp_rdata}, 10'h000);
    rst_n = 1'b1;
    rd_back("R1");

    // R2/R3: every flag pattern with varied low bits, then read back
    for (int p = 0; p < 32; p++) begin
      access("R3", 4'b1011, 8'hFF, 1'b1, 1'b0, 1'b1, {p[4:0], p[2:0] ^ 3'b101}, 5'b0);
      rd_back("R2");
    end

    // R4: each single fault from all ones; stays cleared over repeated reads
    for (int s = 0; s < 5; s++) begin
      access("R3", 4'b1011, 8'hFF, 1'b1, 1'b0, 1'b1, 8'hFF, 5'b0);
      access("R4", 4'b1011, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 5'(1 << s));
      rd_back("R4");
      rd_back("R4");
    end

    // R9: all fault combinations on all ones
    for (int m = 0; m < 32; m++) begin
      access("R3", 4'b1011, 8'hFF, 1'b1, 1'b0, 1'b1, 8'hF8, 5'b0);
      access("R9", 4'b0000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 5'(m));
      rd_back("R9");
    end

    // R5: fault collides with a write of ones
    for (int s = 0; s < 5; s++) begin
      access("R5", 4'b1011, 8'hFF, 1'b1, 1'b0, 1'b1, 8'hFF, 5'(1 << s));
      rd_back("R5");
    end

    // R6: second data byte refused
    access("R3", 4'b1011, 8'hFF, 1'b1, 1'b0, 1'b1, 8'hA8, 5'b0);
    access("R6", 4'b1011, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h50, 5'b0);
    rd_back("R6");

    // R7: all other addresses and all other select codes
    for (int a = 0; a < 255; a++) begin
      access("R7", 4'b1011, 8'(a), 1'b1, 1'b0, 1'b1, 8'h00, 5'b0);
      access("R7", 4'b1011, 8'(a), 1'b0, 1'b1, 1'b0, 8'h00, 5'b0);
    end
    rd_back("R7");
    for (int c = 0; c < 16; c++) begin
      if (c != 11) begin
        access("R7", 4'(c), 8'hFF, 1'b1, 1'b0, 1'b1, 8'h00, 5'b0);
        access("R7", 4'(c), 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00, 5'b0);
      end
    end
    rd_back("R7");

    // R8: read in the same cycle as a fault returns the old value, then the new one
    access("R3", 4'b1011, 8'hFF, 1'b1, 1'b0, 1'b1, 8'hFF, 5'b0);
    access("R8", 4'b1011, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00, 5'b10001);
    rd_back("R8");

    // R1: reset mid-run clears flags
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; model = 8'h00;
    rd_back("R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule